// File: doc/BRIEF.md
# Ping-Pong DMA Channel Engine

This block is one DMA channel. It moves single data items between a peripheral data register and a buffer RAM, in either direction. Each move is started by a trigger pulse on one of twenty selectable request lines, or by software through a manual force bit. Software sets the channel up through a small register port. That port holds the control word, the trigger-source select, two buffer start addresses, the peripheral address and a block length. When software reads back either start-address register, it sees the live buffer pointer, so it can follow the transfer as it runs.

Each move takes two cycles: a read from the source, then a write of that data to the destination. A block is a number of moves. When a block ends, the pointer reloads from a start address. In ping-pong mode that start address alternates between the primary and secondary registers. A one-shot block then disables the channel, while a continuous block leaves it running. The block raises pulse interrupts at the half-way point and at completion. A write collision at either memory sets a sticky flag, and either flag drives an error output that cannot be masked.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, all register reads return 0 (address 0 control, 1 source select, 2/3 start/pointer, 4 peripheral address, 5 count, 6 status), no memory strobe is active, and irq_half, irq_full and err_trap are low.
- R2: A move starts only on a high cycle of trig_in[s], where s is the select register value. A select of 20 or more never starts a move, and select 19 is valid.
- R3: A move reads the source in one cycle and writes the destination in the next. Control bit 13 = 0 moves peripheral (per_addr = peripheral address register) to buffer (buf_addr = pointer). Bit 13 = 1 moves buffer to peripheral.
- R4: With control bit 14 = 1 (byte mode), only data bits 7:0 move and the upper bits are written as 0, and the pointer steps by 1. In word mode the pointer steps by 2. Control bit 11 = 1 keeps the pointer fixed.
- R5: Writing register 2 or 3 loads a start address. Reading either one returns the current pointer. Setting control bit 15 (enable) from 0 loads the pointer from register 2.
- R6: A block is count+1 moves long. When control bit 12 = 1, irq_half pulses for one cycle after move floor((count+1)/2), if that number is nonzero. irq_full pulses for one cycle after the last move.
- R7: At block end the pointer reloads from the active start address. With control bit 0 = 1 (one-shot) the enable bit clears. With bit 0 = 0 the channel stays enabled.
- R8: With control bit 1 = 1 (ping-pong), each block end switches between register 2 and register 3 as the start address. Status bit 2 reads 1 while the secondary buffer is in use.
- R9: Writing control with bit 10 = 1 while the channel is enabled forces exactly one move without a trigger. Bit 10 reads back as 0.
- R10: While enable is 0, trigger pulses cause no move.
- R11: A trigger that arrives during a move is held as one pending request and served after that move. Further triggers that arrive while one is pending are dropped.
- R12: buf_wcol during a buffer write sets status bit 0, and per_wcol during a peripheral write sets status bit 1. Both bits are sticky until 1 is written to them at register 6. err_trap is high while either bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| trig_in | input | 20 | Trigger request lines |
| buf_addr | output | 16 | Buffer RAM address (pointer) |
| buf_re | output | 1 | Buffer read strobe |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer read data, valid the cycle after buf_re |
| buf_wcol | input | 1 | Buffer write collision indication |
| per_addr | output | 16 | Peripheral register address |
| per_re | output | 1 | Peripheral read strobe |
| per_we | output | 1 | Peripheral write strobe |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data, valid the cycle after per_re |
| per_wcol | input | 1 | Peripheral write collision indication |
| irq_half | output | 1 | Half-block interrupt pulse |
| irq_full | output | 1 | Block-complete interrupt pulse |
| err_trap | output | 1 | Non-maskable collision error |

## Verification
The assertions check the rules that must hold on every cycle. A read phase is always followed by a write phase, and at most one memory strobe is active at a time. A disabled idle channel stays idle. The full interrupt is a single-cycle pulse. A word-mode move without fixed addressing steps the pointer by two. Collision flags stay set until they are cleared. A one-shot block end clears the enable bit. Only the bench scenarios can show the rest. These are the data values that land in memory, the byte masking, the exact move after which the half and full interrupts appear, the ping-pong alternation of the start address, the pending-request depth, and trigger-select filtering by source index.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int unsigned RW = 16;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_RSEL = 3'd1;
  localparam logic [2:0] RA_STA  = 3'd2;
  localparam logic [2:0] RA_STB  = 3'd3;
  localparam logic [2:0] RA_PAD  = 3'd4;
  localparam logic [2:0] RA_CNT  = 3'd5;
  localparam logic [2:0] RA_STAT = 3'd6;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} xfer_st_t;

  typedef struct packed {
    logic en;
    logic byte_m;
    logic to_per;
    logic half_ie;
    logic fixed;
    logic ping;
    logic oneshot;
  } ctrl_t;
endpackage

// File: rtl/pp_dma_trigsel.sv
module pp_dma_trigsel #(
  parameter int unsigned NSRC = 20,
  parameter int unsigned SELW = 5
) (
  input  logic [NSRC-1:0] trig,
  input  logic [SELW-1:0] sel,
  output logic            hit
);
  logic [NSRC-1:0] match;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign match[g] = trig[g] & (sel == SELW'(g));
  end

  assign hit = |match;
endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned CW   = 10,
  parameter int unsigned SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      addr,
  input  logic [RW-1:0]   wdata,
  output logic [RW-1:0]   rdata,
  input  logic [AW-1:0]   ptr,
  input  logic            sel_act,
  input  logic            en_clr,
  input  logic            col_buf_set,
  input  logic            col_per_set,
  output ctrl_t           ctrl,
  output logic [SELW-1:0] reqsel,
  output logic [AW-1:0]   sta,
  output logic [AW-1:0]   stb,
  output logic [AW-1:0]   pad,
  output logic [CW-1:0]   cnt,
  output logic            arm,
  output logic            force_p,
  output logic            err
);
  ctrl_t           ctrl_q, ctrl_d;
  logic [SELW-1:0] rsel_q, rsel_d;
  logic [AW-1:0]   sta_q, sta_d, stb_q, stb_d, pad_q, pad_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            bcol_q, bcol_d, pcol_q, pcol_d;
  logic            wr_ctrl, wr_stat;

  always_comb begin
    wr_ctrl = wr && (addr == RA_CTRL);
    wr_stat = wr && (addr == RA_STAT);
    ctrl_d  = ctrl_q;
    rsel_d  = rsel_q;
    sta_d   = sta_q;
    stb_d   = stb_q;
    pad_d   = pad_q;
    cnt_d   = cnt_q;
    if (en_clr) ctrl_d.en = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.en      = wdata[15];
      ctrl_d.byte_m  = wdata[14];
      ctrl_d.to_per  = wdata[13];
      ctrl_d.half_ie = wdata[12];
      ctrl_d.fixed   = wdata[11];
      ctrl_d.ping    = wdata[1];
      ctrl_d.oneshot = wdata[0];
    end
    if (wr && addr == RA_RSEL) rsel_d = wdata[SELW-1:0];
    if (wr && addr == RA_STA)  sta_d  = wdata[AW-1:0];
    if (wr && addr == RA_STB)  stb_d  = wdata[AW-1:0];
    if (wr && addr == RA_PAD)  pad_d  = wdata[AW-1:0];
    if (wr && addr == RA_CNT)  cnt_d  = wdata[CW-1:0];
    bcol_d  = col_buf_set | (bcol_q & ~(wr_stat & wdata[0]));
    pcol_d  = col_per_set | (pcol_q & ~(wr_stat & wdata[1]));
    arm     = wr_ctrl && wdata[15] && !ctrl_q.en;
    force_p = wr_ctrl && wdata[10];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rsel_q <= '0;
      sta_q  <= '0;
      stb_q  <= '0;
      pad_q  <= '0;
      cnt_q  <= '0;
      bcol_q <= 1'b0;
      pcol_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rsel_q <= rsel_d;
      sta_q  <= sta_d;
      stb_q  <= stb_d;
      pad_q  <= pad_d;
      cnt_q  <= cnt_d;
      bcol_q <= bcol_d;
      pcol_q <= pcol_d;
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL: rdata = {ctrl_q.en, ctrl_q.byte_m, ctrl_q.to_per, ctrl_q.half_ie,
                        ctrl_q.fixed, 9'b0, ctrl_q.ping, ctrl_q.oneshot};
      RA_RSEL: rdata = RW'(rsel_q);
      RA_STA,
      RA_STB:  rdata = RW'(ptr);
      RA_PAD:  rdata = RW'(pad_q);
      RA_CNT:  rdata = RW'(cnt_q);
      RA_STAT: rdata = {13'b0, sel_act, pcol_q, bcol_q};
      default: rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign reqsel = rsel_q;
  assign sta    = sta_q;
  assign stb    = stb_q;
  assign pad    = pad_q;
  assign cnt    = cnt_q;
  assign err    = bcol_q | pcol_q;

  assert_bcol_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bcol_q && !(wr_stat && wdata[0])) |=> bcol_q);
  assert_pcol_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pcol_q && !(wr_stat && wdata[1])) |=> pcol_q);
  assert_oneshot_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !wr_ctrl) |=> !ctrl_q.en);
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] sta,
  input  logic [AW-1:0] stb,
  input  logic          req,
  input  logic          arm,
  input  logic [DW-1:0] buf_rdata,
  input  logic [DW-1:0] per_rdata,
  input  logic          buf_wcol,
  input  logic          per_wcol,
  output logic          buf_re,
  output logic          buf_we,
  output logic          per_re,
  output logic          per_we,
  output logic [DW-1:0] mv_data,
  output logic [AW-1:0] ptr,
  output logic          sel_act,
  output logic          en_clr,
  output logic          col_buf_set,
  output logic          col_per_set,
  output logic          irq_half,
  output logic          irq_full
);
  localparam int unsigned IW = CW + 1;

  xfer_st_t      st_q, st_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] ptr_q, ptr_d, step;
  logic [IW-1:0] idx_q, idx_d, done_n, blk_len, half_pt;
  logic          sel_q, sel_d;
  logic          half_q, half_d, full_q, full_d;
  logic          last;
  logic [DW-1:0] src_data;

  always_comb begin
    src_data = ctrl.to_per ? buf_rdata : per_rdata;
    mv_data  = ctrl.byte_m ? {{(DW-8){1'b0}}, src_data[7:0]} : src_data;
    step     = ctrl.fixed ? '0 : (ctrl.byte_m ? AW'(1) : AW'(2));
    blk_len  = {1'b0, cnt} + IW'(1);
    half_pt  = blk_len >> 1;
    done_n   = idx_q + IW'(1);
    last     = (done_n == blk_len);
  end

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    ptr_d  = ptr_q;
    idx_d  = idx_q;
    sel_d  = sel_q;
    half_d = 1'b0;
    full_d = 1'b0;
    en_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ctrl.en && (pend_q || req)) begin
          st_d   = ST_RD;
          pend_d = pend_q && req;
        end
      end
      ST_RD: begin
        st_d = ST_WR;
        if (req) pend_d = 1'b1;
      end
      ST_WR: begin
        st_d  = ST_IDLE;
        if (req) pend_d = 1'b1;
        idx_d = done_n;
        ptr_d = ptr_q + step;
        if (ctrl.half_ie && done_n == half_pt) half_d = 1'b1;
        if (last) begin
          full_d = 1'b1;
          idx_d  = '0;
          sel_d  = ctrl.ping ? ~sel_q : 1'b0;
          ptr_d  = (ctrl.ping && !sel_q) ? stb : sta;
          if (ctrl.oneshot) begin
            en_clr = 1'b1;
            pend_d = 1'b0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!ctrl.en) pend_d = 1'b0;
    if (arm) begin
      ptr_d = sta;
      sel_d = 1'b0;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      ptr_q  <= '0;
      idx_q  <= '0;
      sel_q  <= 1'b0;
      half_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      ptr_q  <= ptr_d;
      idx_q  <= idx_d;
      sel_q  <= sel_d;
      half_q <= half_d;
      full_q <= full_d;
    end
  end

  assign buf_re      = (st_q == ST_RD) &&  ctrl.to_per;
  assign per_re      = (st_q == ST_RD) && !ctrl.to_per;
  assign buf_we      = (st_q == ST_WR) && !ctrl.to_per;
  assign per_we      = (st_q == ST_WR) &&  ctrl.to_per;
  assign col_buf_set = buf_we && buf_wcol;
  assign col_per_set = per_we && per_wcol;
  assign ptr         = ptr_q;
  assign sel_act     = sel_q;
  assign irq_half    = half_q;
  assign irq_full    = full_q;

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_re, buf_we, per_re, per_we}));
  assert_rd_then_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD) |=> (st_q == ST_WR));
  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !ctrl.en) |=> (st_q == ST_IDLE));
  assert_full_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |=> !irq_full);
  assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR && !last && !ctrl.fixed && !ctrl.byte_m && !arm)
      |=> (ptr_q == $past(ptr_q) + AW'(2)));
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 10,
  parameter int unsigned NSRC = 20,
  parameter int unsigned SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] trig_in,
  output logic [AW-1:0]   buf_addr,
  output logic            buf_re,
  output logic            buf_we,
  output logic [DW-1:0]   buf_wdata,
  input  logic [DW-1:0]   buf_rdata,
  input  logic            buf_wcol,
  output logic [AW-1:0]   per_addr,
  output logic            per_re,
  output logic            per_we,
  output logic [DW-1:0]   per_wdata,
  input  logic [DW-1:0]   per_rdata,
  input  logic            per_wcol,
  output logic            irq_half,
  output logic            irq_full,
  output logic            err_trap
);
  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  ctrl_t           ctrl;
  logic [SELW-1:0] reqsel;
  logic [AW-1:0]   sta, stb, pad, ptr;
  logic [CW-1:0]   cnt;
  logic            arm, force_p, hit, sel_act, en_clr;
  logic            col_buf_set, col_per_set;
  logic [DW-1:0]   mv_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pp_dma_trigsel #(.NSRC(NSRC), .SELW(SELW)) u_trig (
    .trig(trig_in), .sel(reqsel), .hit(hit)
  );

  pp_dma_regs #(.AW(AW), .CW(CW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ptr(ptr), .sel_act(sel_act),
    .en_clr(en_clr), .col_buf_set(col_buf_set), .col_per_set(col_per_set),
    .ctrl(ctrl), .reqsel(reqsel), .sta(sta), .stb(stb), .pad(pad), .cnt(cnt),
    .arm(arm), .force_p(force_p), .err(err_trap)
  );

  pp_dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_core_n), .ctrl(ctrl), .cnt(cnt), .sta(sta), .stb(stb),
    .req(hit | force_p), .arm(arm), .buf_rdata(buf_rdata), .per_rdata(per_rdata),
    .buf_wcol(buf_wcol), .per_wcol(per_wcol), .buf_re(buf_re), .buf_we(buf_we),
    .per_re(per_re), .per_we(per_we), .mv_data(mv_data), .ptr(ptr),
    .sel_act(sel_act), .en_clr(en_clr), .col_buf_set(col_buf_set),
    .col_per_set(col_per_set), .irq_half(irq_half), .irq_full(irq_full)
  );

  assign buf_addr  = ptr;
  assign per_addr  = pad;
  assign buf_wdata = mv_data;
  assign per_wdata = mv_data;
endmodule

// File: tb/pp_dma_chan_test.sv
module pp_dma_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 20;

  localparam logic [15:0] C_EN = 16'h8000, C_BYTE = 16'h4000, C_TOPER = 16'h2000,
                          C_HALF = 16'h1000, C_FIX = 16'h0800, C_FORCE = 16'h0400,
                          C_PING = 16'h0002, C_ONE = 16'h0001;

  typedef struct packed {
    logic        to_per;
    logic        byte_m;
    logic        fixed;
    logic [7:0]  start;
    logic [15:0] src;
    logic [15:0] exp_data;
    logic [15:0] exp_ptr;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b0, 1'b0, 8'h10, 16'hA5C3, 16'hA5C3, 16'h0012},
    '{1'b0, 1'b1, 1'b0, 8'h20, 16'hBEEF, 16'h00EF, 16'h0021},
    '{1'b1, 1'b0, 1'b1, 8'h30, 16'h1234, 16'h1234, 16'h0030},
    '{1'b1, 1'b1, 1'b0, 8'h31, 16'h9876, 16'h0076, 16'h0032},
    '{1'b0, 1'b0, 1'b1, 8'h50, 16'hFFFF, 16'hFFFF, 16'h0050}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [NSRC-1:0] trig_in = '0;
  logic [15:0] buf_addr, buf_wdata, per_addr, per_wdata;
  logic [15:0] buf_rdata = '0, per_rdata = '0;
  logic buf_re, buf_we, per_re, per_we, buf_wcol = 1'b0, per_wcol = 1'b0;
  logic irq_half, irq_full, err_trap;

  logic [15:0] buf_mem [256];
  logic [15:0] per_mem [256];
  int we_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  pp_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .buf_addr(buf_addr), .buf_re(buf_re), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .buf_wcol(buf_wcol), .per_addr(per_addr),
    .per_re(per_re), .per_we(per_we), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_wcol(per_wcol), .irq_half(irq_half),
    .irq_full(irq_full), .err_trap(err_trap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (buf_we) buf_mem[buf_addr[7:0]] <= buf_wdata;
    if (buf_re) buf_rdata <= buf_mem[buf_addr[7:0]];
    if (per_we) per_mem[per_addr[7:0]] <= per_wdata;
    if (per_re) per_rdata <= per_mem[per_addr[7:0]];
    if (buf_we || per_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regwr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic regrd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // pulse triggers for one cycle, return at the cycle the move result is visible
  task automatic fire(input logic [NSRC-1:0] v);
    trig_in = v;
    @(negedge clk);
    trig_in = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] ctl, input logic [15:0] sa, input logic [15:0] cn);
    regwr(3'd0, 16'h0000);
    regwr(3'd2, sa);
    regwr(3'd4, 16'h0040);
    regwr(3'd5, cn);
    regwr(3'd1, 16'd2);
    regwr(3'd0, ctl);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int w0;
    for (int i = 0; i < 256; i++) begin buf_mem[i] = 16'hDEAD; per_mem[i] = 16'hDEAD; end
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      regrd(3'(a), rd);
      chk("R1 reg read", {16'h0, rd}, 32'h0);
    end
    chk("R1 outputs", {28'h0, irq_half, irq_full, err_trap, buf_we | per_we}, 32'h0);

    // R3 R4 R5 vector table
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      if (v.to_per) buf_mem[v.start] = v.src; else per_mem[8'h40] = v.src;
      if (v.to_per) per_mem[8'h40] = 16'hDEAD; else buf_mem[v.start] = 16'hDEAD;
      setup(C_EN | (v.to_per ? C_TOPER : 16'h0) | (v.byte_m ? C_BYTE : 16'h0) |
            (v.fixed ? C_FIX : 16'h0), {8'h00, v.start}, 16'd3);
      fire(20'h4);
      if (v.to_per) chk("R3 R4 per data", {16'h0, per_mem[8'h40]}, {16'h0, v.exp_data});
      else          chk("R3 R4 buf data", {16'h0, buf_mem[v.start]}, {16'h0, v.exp_data});
      regrd(3'd2, rd);
      chk("R4 R5 pointer", {16'h0, rd}, {16'h0, v.exp_ptr});
    end
    regrd(3'd3, rd);
    chk("R5 secondary reads pointer", {16'h0, rd}, 32'h0050);

    // R2 trigger select
    setup(C_EN, 16'h0010, 16'd50);
    w0 = we_cnt;
    fire(20'h20);
    chk("R2 other source ignored", we_cnt - w0, 0);
    regwr(3'd1, 16'd25);
    fire('1);
    chk("R2 select out of range", we_cnt - w0, 0);
    regwr(3'd1, 16'd19);
    fire(20'h80000);
    chk("R2 select 19", we_cnt - w0, 1);

    // R10 disabled
    regwr(3'd0, 16'h0000);
    w0 = we_cnt;
    regwr(3'd1, 16'd2);
    fire(20'h4);
    idle(2);
    chk("R10 disabled ignored", we_cnt - w0, 0);

    // R6 R7 one-shot with half interrupt: block of 5, half after move 2
    setup(C_EN | C_HALF | C_ONE, 16'h0080, 16'd4);
    for (int i = 1; i <= 5; i++) begin
      fire(20'h4);
      chk("R6 half irq", {31'h0, irq_half}, {31'h0, i == 2});
      chk("R6 full irq", {31'h0, irq_full}, {31'h0, i == 5});
    end
    regrd(3'd0, rd);
    chk("R7 one-shot clears enable", {31'h0, rd[15]}, 32'h0);
    regrd(3'd2, rd);
    chk("R7 pointer reload", {16'h0, rd}, 32'h0080);
    w0 = we_cnt;
    fire(20'h4);
    chk("R7 R10 stopped after one-shot", we_cnt - w0, 0);

    // R7 continuous
    setup(C_EN, 16'h0090, 16'd1);
    fire(20'h4);
    fire(20'h4);
    chk("R7 continuous full", {31'h0, irq_full}, 32'h1);
    regrd(3'd0, rd);
    chk("R7 continuous stays enabled", {31'h0, rd[15]}, 32'h1);
    regrd(3'd2, rd);
    chk("R7 continuous reload", {16'h0, rd}, 32'h0090);

    // R8 ping-pong, block of 1
    regwr(3'd0, 16'h0000);
    regwr(3'd3, 16'h00C0);
    per_mem[8'h40] = 16'h1111;
    setup(C_EN | C_PING, 16'h00A0, 16'd0);
    fire(20'h4);
    chk("R8 first buffer", {16'h0, buf_mem[8'hA0]}, 32'h1111);
    regrd(3'd2, rd);
    chk("R8 switch to secondary", {16'h0, rd}, 32'h00C0);
    regrd(3'd6, rd);
    chk("R8 status secondary", {29'h0, rd[2:0]}, 32'h4);
    per_mem[8'h40] = 16'h2222;
    fire(20'h4);
    chk("R8 second buffer", {16'h0, buf_mem[8'hC0]}, 32'h2222);
    regrd(3'd2, rd);
    chk("R8 back to primary", {16'h0, rd}, 32'h00A0);

    // R9 manual force
    per_mem[8'h40] = 16'h3333;
    setup(C_EN, 16'h00D0, 16'd9);
    w0 = we_cnt;
    regwr(3'd0, C_EN | C_FORCE);
    idle(2);
    chk("R9 one forced move", we_cnt - w0, 1);
    chk("R9 forced data", {16'h0, buf_mem[8'hD0]}, 32'h3333);
    regrd(3'd0, rd);
    chk("R9 force bit reads 0", {16'h0, rd}, {16'h0, C_EN});

    // R11 one pending request
    setup(C_EN, 16'h0010, 16'd20);
    w0 = we_cnt;
    trig_in = 20'h4;
    idle(3);
    trig_in = '0;
    idle(6);
    chk("R11 pending depth one", we_cnt - w0, 2);
    regrd(3'd2, rd);
    chk("R11 pointer after two", {16'h0, rd}, 32'h0014);

    // R12 collision flags
    setup(C_EN, 16'h0010, 16'd20);
    buf_wcol = 1'b1;
    fire(20'h4);
    buf_wcol = 1'b0;
    regrd(3'd6, rd);
    chk("R12 buffer collision", {16'h0, rd}, 32'h1);
    chk("R12 error out", {31'h0, err_trap}, 32'h1);
    fire(20'h4);
    regrd(3'd6, rd);
    chk("R12 sticky", {16'h0, rd}, 32'h1);
    regwr(3'd6, 16'h0001);
    regrd(3'd6, rd);
    chk("R12 cleared", {15'h0, err_trap, rd}, 32'h0);
    setup(C_EN | C_TOPER, 16'h0010, 16'd20);
    per_wcol = 1'b1;
    fire(20'h4);
    per_wcol = 1'b0;
    regrd(3'd6, rd);
    chk("R12 peripheral collision", {15'h0, err_trap, rd}, 32'h10002);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule